// File: doc/BRIEF.md
# Bridge Window Control Registers

This block is the 32-bit control register file of a bus bridge. It stores eight word-wide registers. Three of them are window map registers, and each one sets where one of three inbound memory windows lands in the far-side address space. The other five are a self-identity register, a flags register and three secondary map registers. Software reads and writes the registers through a simple one-cycle read/write port.

For each window the block takes an address offset within the window and returns a translated far-side address. The result is registered for one cycle. The way a map register becomes a window base depends on a build-time variant select:

- Variant 0 takes the low nibble of the map register as the four top address bits.
- Variant 1 keeps the map register bits that lie above the window size.

Window sizes are parameters, with defaults set by the variant. A sticky flag records any access that is not a full-word access to a defined register.

Top module: `bridge_win_ctrl`

## Requirements
- R1: After reset, all eight registers read as zero, `reg_rdata` is zero, `bad_access_o` is low, and every `win_addr_o` lane is zero.
- R2: A valid access is one with `reg_be` = 4'hF, `reg_addr[1:0]` = 0 and `reg_addr` below 0x20. The register word index is `reg_addr[4:2]`: 0-2 are window maps 0-2, 3 is self-identity, 4 is flags, and 5-7 are secondary maps 0-2. A valid write stores all 32 bits at the clock edge. A valid read returns the stored value on `reg_rdata` from the cycle after `reg_rd_en`, and `reg_rdata` holds until the next read.
- R3: A partial-width access (`reg_be` not 4'hF) or a misaligned access (`reg_addr[1:0]` not 0) is invalid. Such a write changes no register, and such a read returns zero.
- R4: An access at or above offset 0x20 is invalid. Such a write changes no register, and such a read returns zero.
- R5: `bad_access_o` rises in the cycle after any invalid read or write. It stays high until reset, and it stays low while all accesses are valid.
- R6: In variant 0, the window base is map[3:0] placed in address bits 31:28, with all lower bits zero.
- R7: In variant 1, the window base is the map value ANDed with the inverse of (window size − 1).
- R8: Each `win_addr_o` lane is registered. It equals base + (`win_off_i` lane AND offset mask), using the inputs sampled at the previous edge. The offset mask is (size − 1) in variant 1, and (size − 1) AND 0x0FFFFFFF in variant 0. Lane w occupies bits [32w+31:32w].
- R9: A map write at clock edge k does not change the translation computed at edge k. The new base is first used by the translation registered at edge k+1.
- R10: Writes to the self-identity, flags or secondary map registers never change any `win_addr_o` lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_be | input | 4 | Byte enables; only 4'hF is valid |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read |
| bad_access_o | output | 1 | Sticky invalid-access flag |
| win_off_i | input | 3*32 | Per-window incoming offsets |
| win_addr_o | output | 3*32 | Per-window translated addresses |

## Verification
The embedded assertions check the following on every cycle:
- the sticky flag never falls and an invalid read yields zero;
- an invalid write leaves every register stable and a valid write lands in the selected register;
- the low bits of each translated address always carry the masked offset from the previous cycle;
- the upper bits carry the variant's base from the previous cycle's map.

Some properties can only be shown by the bench's scenarios:
- the decoded register order;
- the one-cycle lag between a map write and its effect on translation;
- the isolation of the non-map registers from the windows;
- the flag clearing on a second reset.

For these, a behavioural model of both variants is compared against two instances on every clock.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
    localparam int DATA_W    = 32;
    localparam int REG_COUNT = 8;
    localparam int NWIN      = 3;
    localparam int IDX_W     = $clog2(REG_COUNT);

    typedef enum logic [IDX_W-1:0] {
        IDX_MAP0   = 3'd0,
        IDX_MAP1   = 3'd1,
        IDX_MAP2   = 3'd2,
        IDX_SELFID = 3'd3,
        IDX_FLAGS  = 3'd4,
        IDX_SMAP0  = 3'd5,
        IDX_SMAP1  = 3'd6,
        IDX_SMAP2  = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic     valid;
        reg_idx_e idx;
    } dec_t;
endpackage

// File: rtl/bwc_decode.sv
module bwc_decode
    import bwc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        be,
    output dec_t              dec
);
    localparam int LOW_W = IDX_W + 2;

    logic in_range;
    logic aligned;
    logic full_word;

    always_comb begin
        in_range  = (addr[ADDR_W-1:LOW_W] == '0);
        aligned   = (addr[1:0] == 2'b00);
        full_word = (be == 4'hF);
        dec.valid = in_range && aligned && full_word;
        dec.idx   = reg_idx_e'(addr[LOW_W-1:2]);
    end
endmodule

// File: rtl/bwc_regs.sv
module bwc_regs
    import bwc_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic                         rd_en,
    input  dec_t                         dec,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            rdata,
    output logic                         bad_access,
    output logic [NWIN-1:0][DATA_W-1:0]  map_o
);
    logic [DATA_W-1:0] regs_q [REG_COUNT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < REG_COUNT; r++) begin
                regs_q[r] <= '0;
            end
        end else if (wr_en && dec.valid) begin
            regs_q[dec.idx] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= dec.valid ? regs_q[dec.idx] : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bad_access <= 1'b0;
        end else if ((rd_en || wr_en) && !dec.valid) begin
            bad_access <= 1'b1;
        end
    end

    for (genvar w = 0; w < NWIN; w++) begin : g_map
        assign map_o[w] = regs_q[int'(IDX_MAP0) + w];
    end

    // R5: the flag is sticky until reset
    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bad_access |=> bad_access);

    // R3 / R4: an invalid read gives zero
    assert_bad_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !dec.valid) |=> (rdata == '0));

    // R2: a valid write lands in the addressed register
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dec.valid) |=> (regs_q[$past(dec.idx)] == $past(wdata)));

    for (genvar r = 0; r < REG_COUNT; r++) begin : g_chk
        // R3: an invalid write leaves every register untouched
        assert_bad_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !dec.valid) |=> $stable(regs_q[r]));
    end
endmodule

// File: rtl/bwc_xlate.sv
module bwc_xlate
    import bwc_pkg::*;
#(
    parameter int                VARIANT  = 0,
    parameter logic [DATA_W-1:0] WIN_SIZE = 32'h1000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] map_i,
    input  logic [DATA_W-1:0] off_i,
    output logic [DATA_W-1:0] addr_o
);
    localparam logic [DATA_W-1:0] SIZE_M1  = WIN_SIZE - 32'd1;
    localparam logic [DATA_W-1:0] OFF_MASK = (VARIANT == 0) ? (SIZE_M1 & 32'h0FFF_FFFF) : SIZE_M1;

    logic [DATA_W-1:0] base;

    if (VARIANT == 0) begin : g_nibble
        assign base = {map_i[3:0], {(DATA_W-4){1'b0}}};

        // R6: top nibble follows the previous cycle's map nibble
        assert_nibble_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (addr_o[DATA_W-1:DATA_W-4] == $past(map_i[3:0])));
    end else begin : g_masked
        assign base = map_i & ~SIZE_M1;

        // R7: bits above the window size follow the previous cycle's map
        assert_masked_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> ((addr_o & ~SIZE_M1) == ($past(map_i) & ~SIZE_M1)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_o <= '0;
        end else begin
            addr_o <= base + (off_i & OFF_MASK);
        end
    end

    // R8: low bits carry the masked offset of the previous cycle
    assert_offset_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((addr_o & OFF_MASK) == ($past(off_i) & OFF_MASK)));
endmodule

// File: rtl/bridge_win_ctrl.sv
module bridge_win_ctrl
    import bwc_pkg::*;
#(
    parameter int                VARIANT   = 0,
    parameter int                ADDR_W    = 12,
    parameter logic [DATA_W-1:0] WIN0_SIZE = (VARIANT == 0) ? 32'h0C00_0000 : 32'h0100_0000,
    parameter logic [DATA_W-1:0] WIN1_SIZE = (VARIANT == 0) ? 32'h1000_0000 : 32'h0400_0000,
    parameter logic [DATA_W-1:0] WIN2_SIZE = (VARIANT == 0) ? 32'h1000_0000 : 32'h0800_0000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr_en,
    input  logic                     reg_rd_en,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [3:0]               reg_be,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata,
    output logic                     bad_access_o,
    input  logic [NWIN*DATA_W-1:0]   win_off_i,
    output logic [NWIN*DATA_W-1:0]   win_addr_o
);
    localparam logic [NWIN-1:0][DATA_W-1:0] SIZES = {WIN2_SIZE, WIN1_SIZE, WIN0_SIZE};

    dec_t                        dec;
    logic [NWIN-1:0][DATA_W-1:0] map_w;

    bwc_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (reg_addr),
        .be   (reg_be),
        .dec  (dec)
    );

    bwc_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .rd_en      (reg_rd_en),
        .dec        (dec),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .bad_access (bad_access_o),
        .map_o      (map_w)
    );

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        bwc_xlate #(
            .VARIANT  (VARIANT),
            .WIN_SIZE (SIZES[w])
        ) u_xlate (
            .clk    (clk),
            .rst_n  (rst_n),
            .map_i  (map_w[w]),
            .off_i  (win_off_i[w*DATA_W +: DATA_W]),
            .addr_o (win_addr_o[w*DATA_W +: DATA_W])
        );
    end
endmodule

// File: tb/bridge_win_ctrl_tb.sv
module bridge_win_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [3:0]  reg_be = 4'hF;
    logic [31:0] reg_wdata = '0;
    logic [95:0] win_off_i = '0;
    logic [31:0] rdata0, rdata1;
    logic        bad0, bad1;
    logic [95:0] waddr0, waddr1;

    int  n_tests = 0;
    int  n_fail = 0;
    bit  freeze_off = 1'b0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    bridge_win_ctrl #(.VARIANT(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
        .reg_rdata(rdata0), .bad_access_o(bad0), .win_off_i(win_off_i), .win_addr_o(waddr0));

    bridge_win_ctrl #(.VARIANT(1)) dut_v1_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
        .reg_rdata(rdata1), .bad_access_o(bad1), .win_off_i(win_off_i), .win_addr_o(waddr1));

    // behavioural reference
    logic [31:0] sz [2][3];
    logic [31:0] m_regs [8];
    logic [31:0] e_win [2][3];
    logic [31:0] e_rd = '0;
    bit          e_err = 1'b0;

    initial begin
        sz[0][0] = 32'h0C00_0000; sz[0][1] = 32'h1000_0000; sz[0][2] = 32'h1000_0000;
        sz[1][0] = 32'h0100_0000; sz[1][1] = 32'h0400_0000; sz[1][2] = 32'h0800_0000;
        for (int i = 0; i < 8; i++) m_regs[i] = '0;
        for (int v = 0; v < 2; v++) for (int w = 0; w < 3; w++) e_win[v][w] = '0;
    end

    function automatic logic [31:0] ref_win(int v, logic [31:0] m, logic [31:0] s, logic [31:0] o);
        logic [31:0] b, mk;
        if (v == 0) begin
            b  = m << 28;
            mk = (s - 1) & 32'h0FFF_FFFF;
        end else begin
            b  = m & ~(s - 1);
            mk = s - 1;
        end
        return b + (o & mk);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) m_regs[i] = '0;
            for (int v = 0; v < 2; v++) for (int w = 0; w < 3; w++) e_win[v][w] = '0;
            e_rd = '0;
            e_err = 1'b0;
        end else begin
            bit ok;
            for (int v = 0; v < 2; v++)
                for (int w = 0; w < 3; w++)
                    e_win[v][w] = ref_win(v, m_regs[w], sz[v][w], win_off_i[w*32 +: 32]);
            ok = (reg_addr < 12'h20) && (reg_addr[1:0] == 2'b00) && (reg_be == 4'hF);
            if (reg_rd_en) e_rd = ok ? m_regs[reg_addr[4:2]] : 32'h0;
            if ((reg_rd_en || reg_wr_en) && !ok) e_err = 1'b1;
            if (reg_wr_en && ok) m_regs[reg_addr[4:2]] = reg_wdata;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // every-cycle comparison, 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (!done) begin
            chk(rdata0 == e_rd && rdata1 == e_rd, "R2 rdata", rdata0, e_rd);
            chk(bad0 == e_err && bad1 == e_err, "R5 flag", {31'b0, bad0}, {31'b0, e_err});
            for (int w = 0; w < 3; w++) begin
                chk(waddr0[w*32 +: 32] == e_win[0][w], "R8 v0 window", waddr0[w*32 +: 32], e_win[0][w]);
                chk(waddr1[w*32 +: 32] == e_win[1][w], "R8 v1 window", waddr1[w*32 +: 32], e_win[1][w]);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        if (!freeze_off) win_off_i = {$urandom, $urandom, $urandom};
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
        tick();
        reg_wr_en = 1'b0; reg_be = 4'hF;
    endtask

    task automatic rd(input logic [11:0] a, input logic [3:0] be);
        reg_rd_en = 1'b1; reg_addr = a; reg_be = be;
        tick();
        reg_rd_en = 1'b0; reg_be = 4'hF;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [95:0] save0, save1;
        repeat (3) tick();
        // R1: reset state
        chk(rdata0 == 0 && bad0 == 0 && waddr0 == 0 && waddr1 == 0, "R1 reset outputs", rdata0, 32'h0);
        rst_n = 1'b1;
        tick();

        // R6 / R7 / R9 with frozen offsets
        freeze_off = 1'b1;
        win_off_i = {32'h0, 32'h0, 32'h00FF_0001};
        tick();
        wr(12'h000, 32'hABCD_EF15, 4'hF);
        chk(waddr0[31:0] == 32'h00FF_0001, "R9 old base v0", waddr0[31:0], 32'h00FF_0001);
        chk(waddr1[31:0] == 32'h00FF_0001, "R9 old base v1", waddr1[31:0], 32'h00FF_0001);
        tick();
        chk(waddr0[31:0] == 32'h50FF_0001, "R6 nibble base", waddr0[31:0], 32'h50FF_0001);
        chk(waddr1[31:0] == 32'hABFF_0001, "R7 masked base", waddr1[31:0], 32'hABFF_0001);

        // R10: non-map registers leave windows alone
        save0 = waddr0; save1 = waddr1;
        wr(12'h00C, 32'hFFFF_FFFF, 4'hF);
        wr(12'h010, 32'hFFFF_FFFF, 4'hF);
        wr(12'h014, 32'hFFFF_FFFF, 4'hF);
        wr(12'h018, 32'hFFFF_FFFF, 4'hF);
        wr(12'h01C, 32'hFFFF_FFFF, 4'hF);
        tick();
        chk(waddr0 == save0, "R10 v0 windows unchanged", waddr0[31:0], save0[31:0]);
        chk(waddr1 == save1, "R10 v1 windows unchanged", waddr1[31:0], save1[31:0]);
        freeze_off = 1'b0;

        // R2: full register order
        for (int i = 0; i < 8; i++) wr(12'(i * 4), 32'h1111_0000 + i, 4'hF);
        for (int i = 0; i < 8; i++) begin
            rd(12'(i * 4), 4'hF);
            chk(rdata0 == 32'h1111_0000 + i, "R2 readback", rdata0, 32'h1111_0000 + i);
        end
        chk(bad0 == 1'b0, "R5 flag low on valid traffic", {31'b0, bad0}, 32'h0);

        // R3: partial width and misaligned
        wr(12'h004, 32'hDEAD_BEEF, 4'h3);
        wr(12'h006, 32'hDEAD_BEEF, 4'hF);
        rd(12'h004, 4'hF);
        chk(rdata0 == 32'h1111_0001, "R3 partial write ignored", rdata0, 32'h1111_0001);
        rd(12'h004, 4'h7);
        chk(rdata0 == 32'h0, "R3 partial read zero", rdata0, 32'h0);
        chk(bad0 == 1'b1 && bad1 == 1'b1, "R5 flag set", {31'b0, bad0}, 32'h1);

        // R4: undefined offsets
        wr(12'h020, 32'hCAFE_F00D, 4'hF);
        rd(12'h020, 4'hF);
        chk(rdata0 == 32'h0, "R4 undefined read zero", rdata0, 32'h0);
        rd(12'h000, 4'hF);
        chk(rdata0 == 32'h1111_0000, "R4 undefined write ignored", rdata0, 32'h1111_0000);
        rd(12'h7FC, 4'hF);
        chk(rdata0 == 32'h0, "R4 high offset read zero", rdata0, 32'h0);
        chk(bad0 == 1'b1, "R5 flag stays set", {31'b0, bad0}, 32'h1);

        // R1 / R5: second reset clears everything
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        chk(bad0 == 1'b0 && bad1 == 1'b0, "R5 flag cleared by reset", {31'b0, bad0}, 32'h0);
        for (int i = 0; i < 8; i++) begin
            rd(12'(i * 4), 4'hF);
            chk(rdata0 == 32'h0, "R1 register zero after reset", rdata0, 32'h0);
        end

        // mixed random traffic against the model
        for (int c = 0; c < 600; c++) begin
            int op;
            logic [11:0] a;
            logic [3:0]  b;
            op = int'($urandom % 4);
            a  = 12'(($urandom % 12) * 4);
            if ($urandom % 10 == 0) a = a + 12'($urandom % 4);
            b  = ($urandom % 8 == 0) ? 4'($urandom) : 4'hF;
            if (op == 1) wr(a, $urandom, b);
            else if (op == 2) rd(a, b);
            else tick();
        end
        tick();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule